// File: doc/BRIEF.md
# Line-Buffered Palette Video Output

This block produces a progressive raster for a 640x480 display from a 25 MHz pixel clock and fills its active area with colours taken from a palette. A horizontal position counter and a vertical line counter step through the visible area and the porches and sync pulses around it. While the position is inside the visible area the block reads one entry per pixel pair from a line buffer. It takes a palette index out of a bit field of that entry, reads a 24-bit colour from palette RAM at that index, and drives the colour together with the sync and enable signals. Each line-buffer entry covers two adjacent output pixels, so 320 stored entries fill a 640-pixel line.

There are two line buffers. The block chooses which one it reads with a select output. At the end of every visible line it pulses a swap strobe and flips the select, so that the renderer can fill one buffer while the other is on screen. Two status outputs, the visible-area flag and the vertical-blank flag, decode the current position without delay so that other logic can schedule its work around the display. The raster is a free-running stream with no back-pressure: the sink must take one pixel on every clock. The line buffer and the palette must each answer a read one clock after the address is presented.

Top module: `pal_video_out`

## Requirements
- R1: During reset and until three clocks after reset is released, the outputs hold the idle values de=0, hsync_n=1, vsync_n=1 and rgb=0. The outputs swap=0 and lb_sel=0 hold from reset until the first line end.
- R2: A line lasts H_ACT+H_FP+H_SYNC+H_BP clocks. de is high for the first H_ACT clocks of each visible line. hsync_n is low for H_SYNC clocks, starting H_ACT+H_FP clocks into the line.
- R3: A frame lasts V_ACT+V_FP+V_SYNC+V_BP lines. Only the first V_ACT lines are visible. vsync_n is low for the V_SYNC whole lines that start V_ACT+V_FP lines into the frame.
- R4: For raster position (x,y), lb_rd_en is high and lb_rd_addr equals x/2 in the same clock when the position is visible. Outside the visible area lb_rd_en is low.
- R5: de, hsync_n, vsync_n and rgb for position (x,y) appear three clocks after the position counter shows (x,y). Visible pixels 2i and 2i+1 both carry the colour of line-buffer entry i.
- R6: The palette address is bits [PAL_LSB +: PAL_AW] of the line-buffer entry. All other entry bits have no effect on rgb.
- R7: rgb is zero on every clock in which de is low.
- R8: swap pulses high for exactly one clock, on the clock after the last visible pixel of each visible line is read. lb_sel inverts on that same clock and at no other time.
- R9: Every visible line reads the buffer named by lb_sel. The first visible line after reset reads buffer 0.
- R10: disp is high exactly when the current position is visible. vblank is high exactly when the current line number is V_ACT or more. Both follow the position counter with no delay.
- R11: A reset asserted in the middle of a frame restarts the raster at position (0,0) with lb_sel=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lb_rd_en | output | 1 | Line-buffer read enable |
| lb_sel | output | 1 | Line buffer being displayed (0 or 1) |
| lb_rd_addr | output | $clog2(H_ACT/2) | Line-buffer entry index |
| lb_rd_data | input | ENTRY_W | Entry returned one clock after the address |
| pal_rd_addr | output | PAL_AW | Palette index taken from the entry |
| pal_rd_data | input | RGB_W | Colour returned one clock after the index |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable |
| rgb | output | RGB_W | Pixel colour, zero when de is low |
| disp | output | 1 | Current position is visible |
| vblank | output | 1 | Current line is in vertical blanking |
| swap | output | 1 | One-clock strobe at the end of each visible line |

## Verification
The line-end swap happens on the same clock as the start of the horizontal front porch. The last colour from the old buffer is still inside the fetch pipeline when lb_sel changes. The bench fills the two buffers with different entries and runs whole frames. On every clock it compares the swap strobe, the select, and the pipelined colour of the last pixel pair against a position model. A colour fetched from the wrong buffer, or a swap one clock early or late, shows up as an rgb or lb_sel mismatch at that boundary.

// File: rtl/pvo_pkg.sv
package pvo_pkg;
  // Sync and enable bundle carried down the delay line
  typedef struct packed {
    logic de;
    logic hs_n;
    logic vs_n;
  } vid_ctl_t;

  localparam vid_ctl_t CTL_IDLE = '{de: 1'b0, hs_n: 1'b1, vs_n: 1'b1};

  // Clocks from position counter to output pins
  localparam int unsigned PIPE_LAT = 3;
endpackage

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int unsigned H_ACT  = 640,
  parameter int unsigned H_FP   = 16,
  parameter int unsigned H_SYNC = 96,
  parameter int unsigned H_BP   = 48,
  parameter int unsigned V_ACT  = 480,
  parameter int unsigned V_FP   = 10,
  parameter int unsigned V_SYNC = 2,
  parameter int unsigned V_BP   = 33,
  localparam int unsigned HT = H_ACT + H_FP + H_SYNC + H_BP,
  localparam int unsigned VT = V_ACT + V_FP + V_SYNC + V_BP,
  localparam int unsigned HW = $clog2(HT),
  localparam int unsigned VW = $clog2(VT)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hpos,
  output logic [VW-1:0] vpos,
  output logic          active,
  output logic          hs_n,
  output logic          vs_n,
  output logic          vblank,
  output logic          line_end
);
  localparam logic [HW-1:0] H_LAST  = HW'(HT - 1);
  localparam logic [HW-1:0] H_VIS   = HW'(H_ACT);
  localparam logic [HW-1:0] H_VLAST = HW'(H_ACT - 1);
  localparam logic [HW-1:0] HS_BEG  = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] HS_END  = HW'(H_ACT + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_LAST  = VW'(VT - 1);
  localparam logic [VW-1:0] V_VIS   = VW'(V_ACT);
  localparam logic [VW-1:0] VS_BEG  = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] VS_END  = VW'(V_ACT + V_FP + V_SYNC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hpos <= '0;
      vpos <= '0;
    end else if (hpos == H_LAST) begin
      hpos <= '0;
      vpos <= (vpos == V_LAST) ? '0 : vpos + 1'b1;
    end else begin
      hpos <= hpos + 1'b1;
    end
  end

  logic h_vis, v_vis;
  assign h_vis    = hpos < H_VIS;
  assign v_vis    = vpos < V_VIS;
  assign active   = h_vis && v_vis;
  assign vblank   = !v_vis;
  assign hs_n     = !((hpos >= HS_BEG) && (hpos < HS_END));
  assign vs_n     = !((vpos >= VS_BEG) && (vpos < VS_END));
  assign line_end = (hpos == H_VLAST) && v_vis;
endmodule

// File: rtl/tap_delay.sv
module tap_delay #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stage [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_st
        always_ff @(posedge clk) begin
          if (!rst_n) stage[i] <= INIT;
          else if (i == 0) stage[i] <= d;
          else stage[i] <= stage[(i == 0) ? 0 : i - 1];
        end
      end
      assign q = stage[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/lb_pingpong.sv
module lb_pingpong (
  input  logic clk,
  input  logic rst_n,
  input  logic line_end,
  output logic sel,
  output logic swap
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel  <= 1'b0;
      swap <= 1'b0;
    end else begin
      swap <= line_end;
      if (line_end) sel <= ~sel;
    end
  end
endmodule

// File: rtl/pix_fetch.sv
module pix_fetch #(
  parameter int unsigned HW      = 10,
  parameter int unsigned LBW     = 9,
  parameter int unsigned PIX_REP = 2,
  parameter int unsigned ENTRY_W = 16,
  parameter int unsigned PAL_AW  = 8,
  parameter int unsigned PAL_LSB = 0,
  parameter int unsigned RGB_W   = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HW-1:0]      hpos,
  input  logic               active,
  input  logic               de_p2,
  output logic               lb_rd_en,
  output logic [LBW-1:0]     lb_rd_addr,
  input  logic [ENTRY_W-1:0] lb_rd_data,
  output logic [PAL_AW-1:0]  pal_rd_addr,
  input  logic [RGB_W-1:0]   pal_rd_data,
  output logic [RGB_W-1:0]   rgb
);
  // Stage 0: entry index from position, repeated PIX_REP times
  logic [HW-1:0] xdiv;
  assign xdiv       = hpos / HW'(PIX_REP);
  assign lb_rd_en   = active;
  assign lb_rd_addr = xdiv[LBW-1:0];

  // Stage 1: entry returned, palette index field forwarded
  assign pal_rd_addr = lb_rd_data[PAL_LSB +: PAL_AW];
  logic unused_entry;
  assign unused_entry = ^lb_rd_data;

  // Stage 2: colour returned, blanked outside the visible area
  always_ff @(posedge clk) begin
    if (!rst_n) rgb <= '0;
    else        rgb <= de_p2 ? pal_rd_data : '0;
  end
endmodule

// File: rtl/pal_video_out.sv
module pal_video_out
  import pvo_pkg::*;
#(
  parameter int unsigned H_ACT   = 640,
  parameter int unsigned H_FP    = 16,
  parameter int unsigned H_SYNC  = 96,
  parameter int unsigned H_BP    = 48,
  parameter int unsigned V_ACT   = 480,
  parameter int unsigned V_FP    = 10,
  parameter int unsigned V_SYNC  = 2,
  parameter int unsigned V_BP    = 33,
  parameter int unsigned ENTRY_W = 16,
  parameter int unsigned PAL_AW  = 8,
  parameter int unsigned PAL_LSB = 0,
  parameter int unsigned RGB_W   = 24,
  localparam int unsigned PIX_REP  = 2,
  localparam int unsigned LB_DEPTH = H_ACT / PIX_REP,
  localparam int unsigned LBW = (LB_DEPTH > 1) ? $clog2(LB_DEPTH) : 1,
  localparam int unsigned HW  = $clog2(H_ACT + H_FP + H_SYNC + H_BP),
  localparam int unsigned VW  = $clog2(V_ACT + V_FP + V_SYNC + V_BP)
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               lb_rd_en,
  output logic               lb_sel,
  output logic [LBW-1:0]     lb_rd_addr,
  input  logic [ENTRY_W-1:0] lb_rd_data,
  output logic [PAL_AW-1:0]  pal_rd_addr,
  input  logic [RGB_W-1:0]   pal_rd_data,
  output logic               hsync_n,
  output logic               vsync_n,
  output logic               de,
  output logic [RGB_W-1:0]   rgb,
  output logic               disp,
  output logic               vblank,
  output logic               swap
);
  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;
  logic active, hs_raw, vs_raw, line_end;

  raster_timer #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos),
    .active(active), .hs_n(hs_raw), .vs_n(vs_raw),
    .vblank(vblank), .line_end(line_end)
  );

  assign disp = active;

  // Control bundle: a two-clock tap feeds the blanking gate,
  // the full-latency tap drives the pins alongside rgb
  vid_ctl_t ctl_now, ctl_p2, ctl_out;
  assign ctl_now = '{de: active, hs_n: hs_raw, vs_n: vs_raw};

  tap_delay #(.W($bits(vid_ctl_t)), .DEPTH(PIPE_LAT - 1), .INIT(CTL_IDLE)) u_dly_mid (
    .clk(clk), .rst_n(rst_n), .d(ctl_now), .q(ctl_p2)
  );
  tap_delay #(.W($bits(vid_ctl_t)), .DEPTH(1), .INIT(CTL_IDLE)) u_dly_out (
    .clk(clk), .rst_n(rst_n), .d(ctl_p2), .q(ctl_out)
  );

  assign de      = ctl_out.de;
  assign hsync_n = ctl_out.hs_n;
  assign vsync_n = ctl_out.vs_n;

  pix_fetch #(
    .HW(HW), .LBW(LBW), .PIX_REP(PIX_REP), .ENTRY_W(ENTRY_W),
    .PAL_AW(PAL_AW), .PAL_LSB(PAL_LSB), .RGB_W(RGB_W)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .active(active),
    .de_p2(ctl_p2.de), .lb_rd_en(lb_rd_en), .lb_rd_addr(lb_rd_addr),
    .lb_rd_data(lb_rd_data), .pal_rd_addr(pal_rd_addr),
    .pal_rd_data(pal_rd_data), .rgb(rgb)
  );

  lb_pingpong u_pp (
    .clk(clk), .rst_n(rst_n), .line_end(line_end),
    .sel(lb_sel), .swap(swap)
  );
endmodule

// File: rtl/pal_video_out_chk.sv
module pal_video_out_chk #(
  parameter int unsigned RGB_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             de,
  input logic             hsync_n,
  input logic             vsync_n,
  input logic [RGB_W-1:0] rgb,
  input logic             swap,
  input logic             lb_sel,
  input logic             disp,
  input logic             vblank
);
  assert_black_off_de_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (rgb == '0));

  assert_swap_one_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> !swap);

  assert_sel_flips_on_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swap |-> (lb_sel != $past(lb_sel)));

  assert_sel_holds_otherwise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |-> (lb_sel == $past(lb_sel)));

  assert_status_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    disp |-> !vblank);

  assert_no_sync_in_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync_n && vsync_n));
endmodule

bind pal_video_out pal_video_out_chk #(.RGB_W(RGB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .de(de), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .rgb(rgb), .swap(swap), .lb_sel(lb_sel), .disp(disp), .vblank(vblank)
);

// File: tb/sim_pal_video_out.sv
`timescale 1ns/1ps
module sim_pal_video_out;
  localparam int H_ACT = 8, H_FP = 2, H_SYNC = 3, H_BP = 2;
  localparam int V_ACT = 4, V_FP = 1, V_SYNC = 2, V_BP = 1;
  localparam int HT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int VT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int ENTRY_W = 12, PAL_AW = 6, PAL_LSB = 3, RGB_W = 24;
  localparam int LB_D = H_ACT / 2;
  localparam int LBW = $clog2(LB_D);
  localparam int PAL_D = 1 << PAL_AW;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic lb_rd_en, lb_sel, hsync_n, vsync_n, de, disp, vblank, swap;
  logic [LBW-1:0] lb_rd_addr;
  logic [ENTRY_W-1:0] lb_q;
  logic [PAL_AW-1:0] pal_rd_addr;
  logic [RGB_W-1:0] pal_q, rgb;

  pal_video_out #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .ENTRY_W(ENTRY_W), .PAL_AW(PAL_AW), .PAL_LSB(PAL_LSB), .RGB_W(RGB_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .lb_rd_en(lb_rd_en), .lb_sel(lb_sel),
    .lb_rd_addr(lb_rd_addr), .lb_rd_data(lb_q), .pal_rd_addr(pal_rd_addr),
    .pal_rd_data(pal_q), .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
    .rgb(rgb), .disp(disp), .vblank(vblank), .swap(swap)
  );

  // Bench memories with one-clock read latency
  logic [ENTRY_W-1:0] lbuf [2][LB_D];
  logic [RGB_W-1:0]   pal  [PAL_D];
  always @(posedge clk) begin
    if (lb_rd_en) lb_q <= lbuf[lb_sel][lb_rd_addr];
    pal_q <= pal[pal_rd_addr];
  end

  int checks = 0, fails = 0;
  int k = 0;  // posedges since reset release

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at k=%0d: actual %0h expected %0h", tag, k, act, exp);
    end
  endtask

  function automatic int ends_before(input int n);
    int l, h, v, f;
    l = n / HT; h = n % HT; v = l % VT; f = l / VT;
    return f * V_ACT + ((v < V_ACT) ? v : V_ACT) + ((v < V_ACT && h >= H_ACT) ? 1 : 0);
  endfunction

  function automatic bit vis(input int n);
    return ((n % HT) < H_ACT) && (((n / HT) % VT) < V_ACT);
  endfunction

  function automatic bit is_end(input int n);
    return ((n % HT) == H_ACT - 1) && (((n / HT) % VT) < V_ACT);
  endfunction

  task automatic tick();
    @(posedge clk);
    k++;
    @(negedge clk);
  endtask

  // Compare every output with the position model for the current k
  task automatic check_cycle(input string rgb_tag);
    bit e_de, e_hs, e_vs;
    logic [RGB_W-1:0] e_rgb;
    int p, h, v;
    e_de = 0; e_hs = 1; e_vs = 1; e_rgb = '0;
    if (k >= LAT) begin
      p = k - LAT; h = p % HT; v = (p / HT) % VT;
      e_de = vis(p);
      e_hs = !(h >= H_ACT + H_FP && h < H_ACT + H_FP + H_SYNC);
      e_vs = !(v >= V_ACT + V_FP && v < V_ACT + V_FP + V_SYNC);
      if (e_de) e_rgb = pal[lbuf[ends_before(p) % 2][h / 2][PAL_LSB +: PAL_AW]];
    end
    chk(de == e_de, "R2 de", de, e_de);
    chk(hsync_n == e_hs, "R2 hsync_n", hsync_n, e_hs);
    chk(vsync_n == e_vs, "R3 vsync_n", vsync_n, e_vs);
    chk(rgb == e_rgb, rgb_tag, rgb, e_rgb);
    chk(lb_rd_en == vis(k), "R4 lb_rd_en", lb_rd_en, vis(k));
    if (vis(k)) chk(lb_rd_addr == LBW'((k % HT) / 2), "R4 lb_rd_addr", lb_rd_addr, (k % HT) / 2);
    chk(disp == vis(k), "R10 disp", disp, vis(k));
    chk(vblank == (((k / HT) % VT) >= V_ACT), "R10 vblank", vblank, ((k / HT) % VT) >= V_ACT);
    chk(lb_sel == ends_before(k) % 2, "R8 R9 lb_sel", lb_sel, ends_before(k) % 2);
    chk(swap == (k >= 1 && is_end(k - 1)), "R8 swap", swap, (k >= 1 && is_end(k - 1)));
  endtask

  task automatic t_reset();  // R1
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(de == 0 && hsync_n == 1 && vsync_n == 1, "R1 ctl idle", {de, hsync_n, vsync_n}, 3'b011);
    chk(rgb == '0, "R1 rgb", rgb, 0);
    chk(swap == 0 && lb_sel == 0, "R1 swap/sel", {swap, lb_sel}, 0);
    rst_n = 1'b1;
    k = 0;
  endtask

  task automatic t_frames(input int nframes);  // R2 R3 R4 R5 R7 R8 R9 R10
    check_cycle("R5 R7 R9 rgb");
    repeat (nframes * HT * VT) begin
      tick();
      check_cycle("R5 R7 R9 rgb");
    end
  endtask

  task automatic t_index_field();  // R6: outside-field bits changed, colours must track field only
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < LB_D; i++)
        lbuf[b][i] = lbuf[b][i] ^ ENTRY_W'(~(((1 << PAL_AW) - 1) << PAL_LSB));
    repeat (HT * VT) begin
      tick();
      check_cycle("R6 rgb field");
    end
  endtask

  task automatic t_midreset();  // R11
    repeat (HT * 2 + 5) tick();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(lb_sel == 0 && swap == 0, "R11 sel after reset", lb_sel, 0);
    chk(disp == 1 && vblank == 0, "R11 position zero", {disp, vblank}, 2'b10);
    rst_n = 1'b1;
    k = 0;
    check_cycle("R11 rgb");
    repeat (HT * VT + HT) begin
      tick();
      check_cycle("R11 rgb");
    end
  endtask

  initial begin
    for (int j = 0; j < PAL_D; j++) pal[j] = RGB_W'(24'h1F0000 + j * 24'h030507 + 1);
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < LB_D; i++)
        lbuf[b][i] = ENTRY_W'((((b * 13 + i * 5 + 2) % PAL_D) << PAL_LSB) | (i + b * 3) % 8);
    @(negedge clk);
    t_reset();
    t_frames(2);
    t_index_field();
    t_midreset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule